// File: doc/BRIEF.md
# Configuration and Fuse Programming Controller

This block is the register backend that sits behind a serial slave port. The slave decodes each 5-bit command and its data word and hands them over as a one-cycle strobe. The block holds a small normal-mode configuration register and a 46-bit shadow of a one-time-programmable fuse array. It gates the fuse commands behind an enable-programming step and protects the factory trim bits once a lock fuse is burned. It also sequences fuse burning one bit at a time, and walks the fuses from the top bit down for readback.

The user fields held in the shadow are decoded into the settings that the analog path reads: Hall bias, DC offset select, gain, the two common-mode selects and channel inversion. The configuration register drives sleep (which disables the analog outputs), routing to the test bus and output-buffer bypass. It also has a one-shot global reset that reloads the shadow from the fuses. The fuse array is a behavioural register whose bits can only go from 0 to 1.

Top module: `otp_cfg_ctrl`

## Requirements
- R1: After reset, all fuses and the shadow are 0, every decoded field and `rdata_o` are 0, `out_en_o` is 1 and `busy_o`, `zap_o`, `rb_valid_o` and `gen_rst_o` are 0.
- R2: Command 10111 writes the configuration. Data bit 15 is sleep, bit 9 is test-bus routing and bit 8 is buffer bypass, and all three show on the ports after the next edge. While sleep is 1, `out_en_o` is 0.
- R3: Data bit 14 of command 10111 raises `gen_rst_o` for exactly one cycle. On the edge that ends that cycle, the shadow is reloaded from the fuse array and programming enable is cleared.
- R4: Command 10000 sets programming enable. The fuse commands 11111 (shadow write), 11001 (burn), 01111 (shadow read) and 01001 (readback) have no effect while enable is clear.
- R5: Enable survives a chip-select low pulse if no fuse command was accepted since it was set. It clears when chip select falls after a fuse command has been accepted.
- R6: Shadow bit positions: Hall bias in bits 0-5, DC offset select in bit 6, gain in bits 7-8, cos common-mode in bit 9, sin common-mode in bit 10, channel inversion in bit 11. An accepted 01111 copies the shadow onto `rdata_o` after the next edge.
- R7: Shadow bits 44 and 45 and fuse bits 44 and 45 are never set by a write or a burn.
- R8: Once fuse bit 13 (the lock) is 1, shadow writes and burns can only change bits 0-11.
- R9: A burn visits bits 0 to 45 in ascending order, spending PHASE_LEN cycles on each, with `busy_o` high throughout. `zap_o` pulses for one cycle at the start of a bit's phase only if that bit was requested and is still 0, and the zapped fuse becomes 1.
- R10: Readback visits bits 45 down to 0, spending PHASE_LEN cycles on each, with `rb_valid_o` high. `seq_idx_o` gives the bit number and `rb_bit_o` gives that fuse's value.
- R11: Every command that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select level from the serial slave |
| cmd_valid_i | input | 1 | One-cycle strobe for a decoded command |
| cmd_i | input | 5 | Command code |
| wdata_i | input | 46 | Command data (normal commands use bits 15:0) |
| rdata_o | output | 46 | Shadow contents captured by a shadow read |
| hall_bias_o | output | 6 | Hall bias setting |
| dc_offset_o | output | 1 | DC offset select (0: 1.5 V, 1: 2.5 V) |
| gain_o | output | 2 | Gain setting |
| cm_cos_o | output | 1 | Cos common-mode output select |
| cm_sin_o | output | 1 | Sin common-mode output select |
| invert_o | output | 1 | Channel inversion |
| out_en_o | output | 1 | Analog outputs enabled (low in sleep) |
| test_bus_o | output | 1 | Route channels to the test bus |
| buf_bypass_o | output | 1 | Bypass the output buffer |
| gen_rst_o | output | 1 | One-cycle global reset pulse |
| busy_o | output | 1 | Burn or readback sequence running |
| zap_o | output | 1 | Single-cycle fuse zap pulse |
| seq_idx_o | output | 6 | Fuse bit the sequencer is on |
| rb_valid_o | output | 1 | Readback sequence running |
| rb_bit_o | output | 1 | Fuse value at `seq_idx_o` |

## Verification
A table of shadow writes is used to check the field decode. The entries are isolated Hall-bias, offset and gain patterns and single select bits, which show that each field sits at its own position. A mixed word with the reserved bits set shows that bits 44 and 45 are dropped. A factory-bit write shows that bit 13 can be written while the lock is clear. Directed sequences then check enable gating across chip-select pulses with and without an accepted fuse command. A burn on an unlocked array checks zap timing and ordering, and a shadow write issued during that burn checks that busy commands are ignored. A second burn after the lock is set distinguishes masked bits, already-burned bits and fresh bits. A final readback is compared bit by bit against the fuses expected from both burns.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;
  typedef enum logic [4:0] {
    CMD_WR_CFG   = 5'b10111,
    CMD_EN_PROG  = 5'b10000,
    CMD_WR_OTP   = 5'b11111,
    CMD_PROG_OTP = 5'b11001,
    CMD_RD_OTP   = 5'b01111,
    CMD_RD_ANA   = 5'b01001
  } cmd_e;

  localparam int unsigned HALL_W   = 6;
  localparam int unsigned DC_BIT   = 6;
  localparam int unsigned GAIN_LSB = 7;
  localparam int unsigned CMC_BIT  = 9;
  localparam int unsigned CMS_BIT  = 10;
  localparam int unsigned INV_BIT  = 11;
  localparam int unsigned USER_W   = 12;
  localparam int unsigned LOCK_BIT = 13;
endpackage

// File: rtl/otp_cfg_reg.sv
module otp_cfg_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] bits_i,   // {sleep, gen_rst, test_bus, bypass}
  output logic       sleep_o,
  output logic       grst_o,
  output logic       tbus_o,
  output logic       byp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sleep_o <= 1'b0;
      grst_o  <= 1'b0;
      tbus_o  <= 1'b0;
      byp_o   <= 1'b0;
    end else begin
      grst_o <= 1'b0;  // self-clearing
      if (wr_i) begin
        sleep_o <= bits_i[3];
        grst_o  <= bits_i[2];
        tbus_o  <= bits_i[1];
        byp_o   <= bits_i[0];
      end
    end
  end
endmodule

// File: rtl/otp_cmd_dec.sv
module otp_cmd_dec
  import otp_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       cmd_valid_i,
  input  logic [4:0] cmd_i,
  input  logic       busy_i,
  input  logic       grst_i,
  output logic       prog_en_o,
  output logic       wr_cfg_o,
  output logic       wr_otp_o,
  output logic       prog_o,
  output logic       rd_otp_o,
  output logic       rd_ana_o
);
  logic en_q, ext_q, cs_q;
  logic acc, is_ext, ext_ok, en_set, cs_fall;

  assign acc     = cmd_valid_i & ~busy_i;
  assign is_ext  = (cmd_i == CMD_WR_OTP) | (cmd_i == CMD_PROG_OTP) |
                   (cmd_i == CMD_RD_OTP) | (cmd_i == CMD_RD_ANA);
  assign ext_ok  = acc & is_ext & en_q;
  assign en_set  = acc & (cmd_i == CMD_EN_PROG);
  assign cs_fall = cs_q & ~cs_i;

  assign wr_cfg_o  = acc & (cmd_i == CMD_WR_CFG);
  assign wr_otp_o  = ext_ok & (cmd_i == CMD_WR_OTP);
  assign prog_o    = ext_ok & (cmd_i == CMD_PROG_OTP);
  assign rd_otp_o  = ext_ok & (cmd_i == CMD_RD_OTP);
  assign rd_ana_o  = ext_ok & (cmd_i == CMD_RD_ANA);
  assign prog_en_o = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ext_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      cs_q <= cs_i;
      if (grst_i) begin
        en_q  <= 1'b0;
        ext_q <= 1'b0;
      end else if (cs_fall) begin
        // session ends only once a fuse command was taken
        en_q  <= en_q & ~ext_q;
        ext_q <= 1'b0;
      end else begin
        if (en_set) en_q  <= 1'b1;
        if (ext_ok) ext_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq #(
  parameter int unsigned FUSE_W    = 46,
  parameter int unsigned PHASE_LEN = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_burn_i,
  input  logic                      start_rb_i,
  input  logic [FUSE_W-1:0]         mask_i,
  output logic                      busy_o,
  output logic                      zap_o,
  output logic [$clog2(FUSE_W)-1:0] idx_o,
  output logic                      rb_valid_o,
  output logic                      rb_bit_o,
  output logic [FUSE_W-1:0]         fuse_o
);
  localparam int unsigned IDX_W = $clog2(FUSE_W);
  localparam int unsigned PH_W  = (PHASE_LEN > 1) ? $clog2(PHASE_LEN) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASE_LEN - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FUSE_W - 1);

  logic              act_q, dir_q;  // dir_q: 1 = readback (descending)
  logic [IDX_W-1:0]  idx_q;
  logic [PH_W-1:0]   ph_q;
  logic [FUSE_W-1:0] mask_q, fuse_q;
  logic              at_end;

  assign at_end     = dir_q ? (idx_q == '0) : (idx_q == IDX_LAST);
  assign zap_o      = act_q & ~dir_q & (ph_q == '0) & mask_q[idx_q] & ~fuse_q[idx_q];
  assign busy_o     = act_q;
  assign idx_o      = idx_q;
  assign rb_valid_o = act_q & dir_q;
  assign rb_bit_o   = rb_valid_o & fuse_q[idx_q];
  assign fuse_o     = fuse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      idx_q  <= '0;
      ph_q   <= '0;
      mask_q <= '0;
      fuse_q <= '0;
    end else begin
      if (zap_o) fuse_q[idx_q] <= 1'b1;
      if (!act_q) begin
        if (start_burn_i || start_rb_i) begin
          act_q  <= 1'b1;
          dir_q  <= start_rb_i;
          idx_q  <= start_rb_i ? IDX_LAST : '0;
          ph_q   <= '0;
          mask_q <= mask_i;
        end
      end else if (ph_q == PH_LAST) begin
        ph_q <= '0;
        if (at_end) act_q <= 1'b0;
        else        idx_q <= dir_q ? idx_q - IDX_W'(1) : idx_q + IDX_W'(1);
      end else begin
        ph_q <= ph_q + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/otp_cfg_ctrl.sv
module otp_cfg_ctrl
  import otp_cfg_pkg::*;
#(
  parameter int unsigned FUSE_W    = 46,
  parameter int unsigned PHASE_LEN = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_i,
  input  logic                      cmd_valid_i,
  input  logic [4:0]                cmd_i,
  input  logic [FUSE_W-1:0]         wdata_i,
  output logic [FUSE_W-1:0]         rdata_o,
  output logic [HALL_W-1:0]         hall_bias_o,
  output logic                      dc_offset_o,
  output logic [1:0]                gain_o,
  output logic                      cm_cos_o,
  output logic                      cm_sin_o,
  output logic                      invert_o,
  output logic                      out_en_o,
  output logic                      test_bus_o,
  output logic                      buf_bypass_o,
  output logic                      gen_rst_o,
  output logic                      busy_o,
  output logic                      zap_o,
  output logic [$clog2(FUSE_W)-1:0] seq_idx_o,
  output logic                      rb_valid_o,
  output logic                      rb_bit_o
);
  localparam logic [FUSE_W-1:0] USER_MASK = FUSE_W'((1 << USER_W) - 1);
  localparam logic [FUSE_W-1:0] RSV_MASK  = {2'b11, {(FUSE_W-2){1'b0}}};

  logic              prog_en, wr_cfg, wr_otp, do_prog, rd_otp, rd_ana;
  logic              sleep, grst;
  logic [FUSE_W-1:0] fuse_w, shadow_q, wmask;

  otp_cmd_dec u_dec (
    .clk_i, .rst_ni, .cs_i, .cmd_valid_i, .cmd_i,
    .busy_i   (busy_o),
    .grst_i   (grst),
    .prog_en_o(prog_en),
    .wr_cfg_o (wr_cfg),
    .wr_otp_o (wr_otp),
    .prog_o   (do_prog),
    .rd_otp_o (rd_otp),
    .rd_ana_o (rd_ana)
  );

  otp_cfg_reg u_cfg (
    .clk_i, .rst_ni,
    .wr_i   (wr_cfg),
    .bits_i ({wdata_i[15], wdata_i[14], wdata_i[9], wdata_i[8]}),
    .sleep_o(sleep),
    .grst_o (grst),
    .tbus_o (test_bus_o),
    .byp_o  (buf_bypass_o)
  );

  // lock confines changes to the user fields; reserved bits never writable
  assign wmask = (fuse_w[LOCK_BIT] ? USER_MASK : '1) & ~RSV_MASK;

  otp_fuse_seq #(.FUSE_W(FUSE_W), .PHASE_LEN(PHASE_LEN)) u_seq (
    .clk_i, .rst_ni,
    .start_burn_i(do_prog),
    .start_rb_i  (rd_ana),
    .mask_i      (wdata_i & wmask),
    .busy_o,
    .zap_o,
    .idx_o       (seq_idx_o),
    .rb_valid_o,
    .rb_bit_o,
    .fuse_o      (fuse_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      rdata_o  <= '0;
    end else begin
      if (grst)        shadow_q <= fuse_w;
      else if (wr_otp) shadow_q <= (shadow_q & ~wmask) | (wdata_i & wmask);
      if (rd_otp) rdata_o <= shadow_q;
    end
  end

  assign hall_bias_o = shadow_q[HALL_W-1:0];
  assign dc_offset_o = shadow_q[DC_BIT];
  assign gain_o      = shadow_q[GAIN_LSB +: 2];
  assign cm_cos_o    = shadow_q[CMC_BIT];
  assign cm_sin_o    = shadow_q[CMS_BIT];
  assign invert_o    = shadow_q[INV_BIT];
  assign out_en_o    = ~sleep;
  assign gen_rst_o   = grst;
endmodule

// File: rtl/otp_cfg_chk.sv
module otp_cfg_chk
  import otp_cfg_pkg::*;
#(
  parameter int unsigned FUSE_W    = 46,
  parameter int unsigned PHASE_LEN = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cmd_valid_i,
  input logic [4:0]                cmd_i,
  input logic                      busy_i,
  input logic                      zap_i,
  input logic                      gen_rst_i,
  input logic                      rb_valid_i,
  input logic [$clog2(FUSE_W)-1:0] seq_idx_i,
  input logic                      prog_en_i,
  input logic [FUSE_W-1:0]         fuse_i,
  input logic [FUSE_W-1:0]         shadow_i
);
  localparam int unsigned IDX_W = $clog2(FUSE_W);

  p_zap_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zap_i |=> !zap_i);

  p_zap_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zap_i |-> busy_i);

  p_fuse_mono_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(fuse_i) & ~fuse_i) == '0));

  p_rsv_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_i[FUSE_W-1 -: 2] == 2'b00) && (shadow_i[FUSE_W-1 -: 2] == 2'b00));

  p_grst_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_rst_i |=> !gen_rst_i);

  p_grst_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_rst_i |=> (shadow_i == $past(fuse_i)) && !prog_en_i);

  p_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !prog_en_i && !gen_rst_i && cmd_i == CMD_WR_OTP) |=> $stable(shadow_i));

  p_busy_ign_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_i && !gen_rst_i && cmd_i == CMD_WR_OTP) |=> $stable(shadow_i));

  p_lock_shadow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_i[LOCK_BIT] && !gen_rst_i) |=> $stable(shadow_i[FUSE_W-1:USER_W]));

  p_lock_zap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_i[LOCK_BIT] && zap_i && $past(fuse_i[LOCK_BIT])) |-> (seq_idx_i < IDX_W'(USER_W)));

  p_rb_order_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_valid_i && $past(rb_valid_i) && seq_idx_i != $past(seq_idx_i))
      |-> (seq_idx_i == $past(seq_idx_i) - IDX_W'(1)));
endmodule

bind otp_cfg_ctrl otp_cfg_chk #(.FUSE_W(FUSE_W), .PHASE_LEN(PHASE_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_i      (cmd_i),
  .busy_i     (busy_o),
  .zap_i      (zap_o),
  .gen_rst_i  (gen_rst_o),
  .rb_valid_i (rb_valid_o),
  .seq_idx_i  (seq_idx_o),
  .prog_en_i  (prog_en),
  .fuse_i     (fuse_w),
  .shadow_i   (shadow_q)
);

// File: tb/sim_otp_cfg_ctrl.sv
`timescale 1ns/1ps
module sim_otp_cfg_ctrl;
  localparam int FW = 46;
  localparam int PH = 4;
  localparam int NV = 8;

  localparam logic [4:0] C_CFG = 5'b10111, C_EN = 5'b10000, C_WR = 5'b11111,
                         C_PROG = 5'b11001, C_RD = 5'b01111, C_ANA = 5'b01001;

  // shadow write data, expected {inv,cm_sin,cm_cos,gain,dc,hall}, expected read data
  localparam logic [FW-1:0] V_DATA [NV] = '{46'h0000_0000_003F, 46'h0000_0000_0040,
    46'h0000_0000_0180, 46'h0000_0000_0200, 46'h0000_0000_0400, 46'h0000_0000_0800,
    46'h3000_0000_0A55, 46'h0000_0000_2000};
  localparam logic [11:0] V_FLD [NV] = '{12'b0_0_0_00_0_111111, 12'b0_0_0_00_1_000000,
    12'b0_0_0_11_0_000000, 12'b0_0_1_00_0_000000, 12'b0_1_0_00_0_000000,
    12'b1_0_0_00_0_000000, 12'b1_0_1_00_1_010101, 12'b0_0_0_00_0_000000};
  localparam logic [FW-1:0] V_RD [NV] = '{46'h003F, 46'h0040, 46'h0180, 46'h0200,
    46'h0400, 46'h0800, 46'h0A55, 46'h2000};

  logic clk = 1'b0, rst_ni = 1'b0, cs = 1'b0, cmd_valid = 1'b0;
  logic [4:0] cmd = '0;
  logic [FW-1:0] wdata = '0, rdata;
  logic [5:0] hall, seq_idx;
  logic [1:0] gain;
  logic dc, cmc, cms, inv, out_en, tbus, byp, grst, busy, zap, rbv, rbb;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  otp_cfg_ctrl #(.FUSE_W(FW), .PHASE_LEN(PH)) u0 (
    .clk_i(clk), .rst_ni, .cs_i(cs), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .wdata_i(wdata), .rdata_o(rdata), .hall_bias_o(hall), .dc_offset_o(dc),
    .gain_o(gain), .cm_cos_o(cmc), .cm_sin_o(cms), .invert_o(inv),
    .out_en_o(out_en), .test_bus_o(tbus), .buf_bypass_o(byp), .gen_rst_o(grst),
    .busy_o(busy), .zap_o(zap), .seq_idx_o(seq_idx), .rb_valid_o(rbv), .rb_bit_o(rbb)
  );

  function automatic logic [11:0] fields();
    return {inv, cms, cmc, gain, dc, hall};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] c, input logic [FW-1:0] d);
    cmd_valid = 1'b1; cmd = c; wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; wdata = '0;
  endtask

  task automatic cs_pulse();
    cs = 1'b0; @(negedge clk);
    cs = 1'b1; @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int bad;
    logic [FW-1:0] exp_fuse;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fields", {rdata, fields()}, '0);
    chk("R1 ctrl", {out_en, tbus, byp, grst, busy, zap, rbv}, 7'b1000000);
    rst_ni = 1'b1; @(negedge clk);
    cs = 1'b1; @(negedge clk);

    // R4 fuse command without enable is dropped
    send(C_WR, 46'h0FFF);
    chk("R4 write without enable", fields(), 12'h000);

    // R6/R7 field decode table
    send(C_EN, '0);
    for (int i = 0; i < NV; i++) begin
      send(C_WR, V_DATA[i]);
      chk("R6 field decode", fields(), V_FLD[i]);
      send(C_RD, '0);
      chk("R6/R7 shadow read", rdata, V_RD[i]);
    end

    // R5 enable clears at chip-select fall after an accepted fuse command
    cs_pulse();
    send(C_WR, 46'h003F);
    chk("R5 enable cleared after session", hall, 6'h00);
    send(C_EN, '0);
    cs_pulse();
    send(C_WR, 46'h003F);
    chk("R5 enable kept across bare CS pulse", hall, 6'h3F);
    cs_pulse();
    send(C_WR, 46'h0000);
    chk("R5 enable cleared again", hall, 6'h3F);

    // R2 configuration
    send(C_CFG, 46'h8300);
    chk("R2 sleep/test/bypass", {out_en, tbus, byp, grst}, 4'b0110);
    send(C_CFG, 46'h0000);
    chk("R2 wake", {out_en, tbus, byp}, 3'b100);

    // R3 global reset: one-cycle pulse, shadow reload from fuses (all 0)
    send(C_CFG, 46'h4000);
    chk("R3 pulse high", grst, 1'b1);
    @(negedge clk);
    chk("R3 pulse gone", grst, 1'b0);
    chk("R3 shadow reloaded", hall, 6'h00);

    // R9 burn bits 0,3,13 (44 is reserved, R7); R11 write during burn ignored
    send(C_EN, '0);
    send(C_PROG, (46'd1 << 0) | (46'd1 << 3) | (46'd1 << 13) | (46'd1 << 44));
    exp_fuse = (46'd1 << 0) | (46'd1 << 3) | (46'd1 << 13);
    bad = 0;
    for (int c = 0; c < FW * PH; c++) begin
      if (zap !== ((c % PH == 0) && exp_fuse[c / PH])) bad++;
      if (busy !== 1'b1) bad++;
      if (c == 5) begin cmd_valid = 1'b1; cmd = C_WR; wdata = '1; end
      @(negedge clk);
      if (c == 5) begin cmd_valid = 1'b0; wdata = '0; end
    end
    chk("R9 zap pattern mismatches", bad, 0);
    chk("R9 busy drops", busy, 1'b0);
    send(C_RD, '0);
    chk("R11 write during burn ignored", rdata, 46'h0);

    // R3 reload brings burned fuses into shadow, enable cleared
    send(C_CFG, 46'h4000);
    @(negedge clk);
    chk("R3 reload from fuses", hall, 6'h09);
    send(C_WR, 46'h0000);
    chk("R3 enable cleared by reset", hall, 6'h09);

    // R8 lock now set: only user bits writable / burnable
    send(C_EN, '0);
    send(C_WR, '1);
    send(C_RD, '0);
    chk("R8 locked shadow write", rdata, 46'h2FFF);
    send(C_PROG, (46'd1 << 0) | (46'd1 << 1) | (46'd1 << 20));
    bad = 0;
    for (int c = 0; c < FW * PH; c++) begin
      if (zap !== (c == PH)) bad++;
      @(negedge clk);
    end
    chk("R8/R9 locked burn zaps only bit 1", bad, 0);
    exp_fuse[1] = 1'b1;

    // R10 readback from bit 45 downward
    send(C_ANA, '0);
    bad = 0;
    for (int c = 0; c < FW * PH; c++) begin
      if (rbv !== 1'b1) bad++;
      if (seq_idx !== 6'(FW - 1 - c / PH)) bad++;
      if (rbb !== exp_fuse[FW - 1 - c / PH]) bad++;
      @(negedge clk);
    end
    chk("R10 readback order and values", bad, 0);
    chk("R10 readback done", {rbv, busy}, 2'b00);
    finish_run();
  end
endmodule